// File: doc/BRIEF.md
# Burst-of-two DDR static memory with split data ports

This block is a synthesizable model of a static memory with one input data port and one output data port. Each port moves two words per clock cycle, one on each clock phase. A command is taken on every rising edge of the main clock `k`. The inputs are an address, a read/write select and an active-low load strobe. Every command moves a fixed burst of two words, at address A and at A+1. The address wraps modulo the array depth.

Reads and writes can follow each other in any order, one per cycle. Runs of reads alone, or writes alone, keep their port busy every cycle. Read data is registered on the rising edge after the command. It leaves on the output port as two half-cycle beats. Echo clocks run in phase with those beats. The phase comes from an output clock pair, unless both wires of that pair are tied high; then the main clock sets the phase. Write data arrives on the same cycle as the write command. One beat is sampled on the rising edge and one on the falling edge, each with its own active-low byte-write enables.

Top module: `sio_ddr_sram`

## Requirements
- R1: A cycle with `ld_n` high at the rising edge of `k` is a deselect. It leaves the array unchanged, and `q` is all zeros through both phases of the following cycle.
- R2: With `ld_n` low and `rw` high at rising edge n, `q` carries the word at A while the output phase is high in the cycle after edge n+1, and the word at A+1 while it is low.
- R3: With `ld_n` low and `rw` low at rising edge n, `d` sampled at that rising edge is written to A. `d` sampled at the following falling edge is written to A+1.
- R4: Bit i of `bw_n`, when low, enables byte lane i, which is bits [i*LANE_W +: LANE_W]. It is sampled together with each write beat. A lane whose bit is high keeps its old content.
- R5: When A is DEPTH-1, the second word of the burst uses address 0, for both reads and writes.
- R6: Back-to-back reads and back-to-back writes are each accepted at one command per `k` cycle, with every read producing its burst in the next cycle.
- R7: A read issued in the cycle right after a write to the same address returns the merged new data. A read issued in the cycle right before a write returns the old data.
- R8: When `c` and `c_n` are both high, the output phase is `k`. Otherwise the output phase is `c`, so `q` shows the first word while `c` is high.
- R9: `cq` equals the output phase and `cq_n` is its complement.
- R10: `rst` is synchronous and active high. At a rising edge with `rst` high, pending reads and writes are cancelled and `q` goes to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| k | input | 1 | Main clock; commands on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low load strobe; high means deselect |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Burst start address |
| d | input | DATA_W | Write data, two beats per cycle |
| bw_n | input | LANES | Active-low byte-write enables per beat |
| c | input | 1 | Output clock |
| c_n | input | 1 | Output clock complement |
| q | output | DATA_W | Read data, two beats per cycle |
| cq | output | 1 | Echo clock in phase with first beat |
| cq_n | output | 1 | Echo clock complement |

## Verification
A read issued at rising edge n shows its first word just after edge n+1 and its second word just after the following falling edge. The bench therefore pairs each command with the samples taken during the next cycle's task call, 2 ns after each edge. Writes are applied to the bench's array model when they are issued, and any read is checked against that model one cycle later. This covers read-after-write (R7) and the deselect zeros (R1). Echo clock levels are sampled at the same two points and compared with the phase that the bench selects through `c` and `c_n`.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int DEF_LANE_W = 9;
    localparam int DEF_LANES  = 2;
    localparam int DEF_DEPTH  = 16;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic load_n, input logic rd_wr);
        if (load_n) return OP_NOP;
        return rd_wr ? OP_READ : OP_WRITE;
    endfunction

    function automatic int unsigned wrap_next(input int unsigned a, input int unsigned depth);
        return (a + 1 >= depth) ? 0 : a + 1;
    endfunction

endpackage

// File: rtl/sio_wr_capture.sv
module sio_wr_capture import sio_pkg::*; #(
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int DATA_W = LANE_W * LANES,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              k,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d,
    input  logic [LANES-1:0]  bw_n,
    output logic              wr_pend,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_d0,
    output logic [LANES-1:0]  wr_m0,
    output logic [DATA_W-1:0] wr_d1,
    output logic [LANES-1:0]  wr_m1
);
    // first beat with the command on the rising edge
    always_ff @(posedge k) begin
        if (rst) begin
            wr_pend <= 1'b0;
        end else begin
            wr_pend <= (op == OP_WRITE);
        end
        if (op == OP_WRITE) begin
            wr_addr <= addr;
            wr_d0   <= d;
            wr_m0   <= ~bw_n;
        end
    end

    // second beat on the falling edge of the same cycle
    always_ff @(negedge k) begin
        wr_d1 <= d;
        wr_m1 <= ~bw_n;
    end

    // captured address holds while no new write arrives (R3)
    assert_wr_hold_R3: assert property (@(posedge k) disable iff (rst)
        (op != OP_WRITE) |=> $stable(wr_addr));

endmodule

// File: rtl/sio_array.sv
module sio_array import sio_pkg::*; #(
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int DATA_W = LANE_W * LANES,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              k,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_pend,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_d0,
    input  logic [LANES-1:0]  wr_m0,
    input  logic [DATA_W-1:0] wr_d1,
    input  logic [LANES-1:0]  wr_m1,
    output logic              rd_pend,
    output logic [DATA_W-1:0] rd_w0,
    output logic [DATA_W-1:0] rd_w1
);
    logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr_nx;
    logic [ADDR_W-1:0] rd_addr_nx;

    always_comb begin
        wr_addr_nx = ADDR_W'(wrap_next(int'(wr_addr), DEPTH));
        rd_addr_nx = ADDR_W'(wrap_next(int'(rd_addr), DEPTH));
    end

    // commit both beats of the previous cycle's write, per lane
    always_ff @(posedge k) begin
        if (!rst && wr_pend) begin
            for (int g = 0; g < LANES; g++) begin
                if (wr_m0[g]) mem[wr_addr][g]    <= wr_d0[g*LANE_W +: LANE_W];
                if (wr_m1[g]) mem[wr_addr_nx][g] <= wr_d1[g*LANE_W +: LANE_W];
            end
        end
    end

    // read: address on command edge, data registered on the next edge
    always_ff @(posedge k) begin
        if (rst) begin
            rd_pend <= 1'b0;
            rd_w0   <= '0;
            rd_w1   <= '0;
        end else begin
            rd_pend <= (op == OP_READ);
            if (op == OP_READ) rd_addr <= addr;
            if (rd_pend) begin
                rd_w0 <= mem[rd_addr];
                rd_w1 <= mem[rd_addr_nx];
            end else begin
                rd_w0 <= '0;
                rd_w1 <= '0;
            end
        end
    end

endmodule

// File: rtl/sio_out_drive.sv
module sio_out_drive import sio_pkg::*; #(
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              k,
    input  logic              c,
    input  logic              c_n,
    input  logic [DATA_W-1:0] w0,
    input  logic [DATA_W-1:0] w1,
    output logic [DATA_W-1:0] q,
    output logic              cq,
    output logic              cq_n
);
    logic phase_hi;

    always_comb begin
        phase_hi = (c && c_n) ? k : c;
        q        = phase_hi ? w0 : w1;
        cq       = phase_hi;
        cq_n     = ~phase_hi;
    end

endmodule

// File: rtl/sio_ddr_sram.sv
module sio_ddr_sram import sio_pkg::*; #(
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int DATA_W = LANE_W * LANES,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              k,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d,
    input  logic [LANES-1:0]  bw_n,
    input  logic              c,
    input  logic              c_n,
    output logic [DATA_W-1:0] q,
    output logic              cq,
    output logic              cq_n
);
    op_e               cur_op;
    logic              wr_pend;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_d0, wr_d1;
    logic [LANES-1:0]  wr_m0, wr_m1;
    logic              rd_pend;
    logic [DATA_W-1:0] rd_w0, rd_w1;

    always_comb cur_op = decode_op(ld_n, rw);

    sio_wr_capture #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(DEPTH)) cap_i (
        .k(k), .rst(rst), .op(cur_op), .addr(addr), .d(d), .bw_n(bw_n),
        .wr_pend(wr_pend), .wr_addr(wr_addr), .wr_d0(wr_d0), .wr_m0(wr_m0),
        .wr_d1(wr_d1), .wr_m1(wr_m1)
    );

    sio_array #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(DEPTH)) arr_i (
        .k(k), .rst(rst), .op(cur_op), .addr(addr),
        .wr_pend(wr_pend), .wr_addr(wr_addr), .wr_d0(wr_d0), .wr_m0(wr_m0),
        .wr_d1(wr_d1), .wr_m1(wr_m1),
        .rd_pend(rd_pend), .rd_w0(rd_w0), .rd_w1(rd_w1)
    );

    sio_out_drive #(.LANE_W(LANE_W), .LANES(LANES)) drv_i (
        .k(k), .c(c), .c_n(c_n), .w0(rd_w0), .w1(rd_w1),
        .q(q), .cq(cq), .cq_n(cq_n)
    );

    // deselect gives idle words during the cycle after the next edge (R1)
    assert_deselect_idle_R1: assert property (@(posedge k) disable iff (rst)
        ld_n |=> ##1 (rd_w0 == '0 && rd_w1 == '0));

    // one command per cycle: never a write commit and a read fetch together (R6)
    assert_single_op_R6: assert property (@(posedge k) disable iff (rst)
        $onehot0({wr_pend, rd_pend}));

    // read right after a full-mask write to the same address sees its first beat (R7)
    assert_raw_forward_R7: assert property (@(posedge k) disable iff (rst)
        (cur_op == OP_READ && $past(cur_op) == OP_WRITE && !$past(rst) &&
         addr == $past(addr) && $past(bw_n) == '0)
        |=> ##1 (rd_w0 == $past(d, 3)));

    // echo clock follows k while the output pair is tied high (R9)
    assert_echo_bypass_R9: assert property (@(negedge k) disable iff (rst)
        (c && c_n) |-> (cq && !cq_n));

endmodule

// File: tb/sio_ddr_sram_tb.sv
module sio_ddr_sram_tb_top;
    localparam int LW    = 9;
    localparam int NL    = 2;
    localparam int DEPTH = 16;
    localparam int DW    = LW * NL;
    localparam int AW    = 4;

    logic          k = 1'b0;
    logic          rst = 1'b1;
    logic          ld_n = 1'b1;
    logic          rw = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] d = '0;
    logic [NL-1:0] bw_n = '1;
    logic          c, c_n;
    logic [DW-1:0] q;
    logic          cq, cq_n;
    logic          cswap = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DW-1:0] mdl [DEPTH];
    logic [DW-1:0] exp_w0 = '0;
    logic [DW-1:0] exp_w1 = '0;
    string         exp_tag = "R10";

    always #5 k = ~k;   // 100 MHz

    assign c   = cswap ? ~k : 1'b1;
    assign c_n = cswap ?  k : 1'b1;

    sio_ddr_sram #(.LANE_W(LW), .LANES(NL), .DEPTH(DEPTH)) dut_i (
        .k(k), .rst(rst), .ld_n(ld_n), .rw(rw), .addr(addr), .d(d), .bw_n(bw_n),
        .c(c), .c_n(c_n), .q(q), .cq(cq), .cq_n(cq_n)
    );

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'((a * 1093 + s * 611 + 77) % (1 << DW));
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [NL-1:0] b);
        logic [DW-1:0] r = old;
        for (int i = 0; i < NL; i++)
            if (!b[i]) r[i*LW +: LW] = nw[i*LW +: LW];
        return r;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // one k cycle; samples taken here belong to the previous command
    task automatic cyc(input bit r, input bit ldn, input bit rwv, input int a,
                       input logic [DW-1:0] d0, input logic [NL-1:0] b0,
                       input logic [DW-1:0] d1, input logic [NL-1:0] b1, input string tag);
        logic [DW-1:0] n0, n1, qh, ql, eh, el;
        logic cqh, cql, cqnh, cqnl;
        int a1 = (a + 1) % DEPTH;
        rst = r; ld_n = ldn; rw = rwv; addr = AW'(a); d = d0; bw_n = b0;
        n0 = '0; n1 = '0;
        if (!r && !ldn && rwv) begin n0 = mdl[a]; n1 = mdl[a1]; end
        if (!r && !ldn && !rwv) begin
            mdl[a]  = merge(mdl[a], d0, b0);
            mdl[a1] = merge(mdl[a1], d1, b1);
        end
        if (r) begin exp_w0 = '0; exp_w1 = '0; end
        @(posedge k); #2;
        qh = q; cqh = cq; cqnh = cq_n;
        d = d1; bw_n = b1;
        @(negedge k); #2;
        ql = q; cql = cq; cqnl = cq_n;
        eh = cswap ? exp_w1 : exp_w0;
        el = cswap ? exp_w0 : exp_w1;
        check({exp_tag, " high phase"}, qh, eh);
        check({exp_tag, " low phase"}, ql, el);
        check("R9 cq high phase", DW'(cqh), DW'(!cswap));
        check("R9 cq low phase", DW'(cql), DW'(cswap));
        check("R9 cq_n complement", DW'(cqnh ^ cqh) & DW'(cqnl ^ cql), DW'(1));
        exp_w0 = n0; exp_w1 = n1; exp_tag = tag;
    endtask

    task automatic nop(input string tag);
        cyc(0, 1, 1, 3, pat(99, 1), '0, pat(98, 2), '0, tag);
    endtask

    task automatic rd(input int a, input string tag);
        cyc(0, 0, 1, a, '0, '1, '0, '1, tag);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d0, input logic [NL-1:0] b0,
                      input logic [DW-1:0] d1, input logic [NL-1:0] b1, input string tag);
        cyc(0, 0, 0, a, d0, b0, d1, b1, tag);
    endtask

    initial begin
        // R10: reset state
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, '0, '1, '0, '1, "R10");
        // R3/R6: back-to-back writes filling the array
        for (int a = 0; a < DEPTH; a += 2) wr(a, pat(a, 0), '0, pat(a + 1, 0), '0, "R3");
        // R1: deselects with noisy data must not alter memory
        nop("R1"); nop("R1");
        // R2/R6/R5: back-to-back read sweep, last one wraps
        for (int a = 0; a < DEPTH; a++) rd(a, (a == DEPTH - 1) ? "R5" : "R6");
        nop("R1");
        // R4/R7: byte enable sweep, each read right after its write
        for (int b0 = 0; b0 < 4; b0++)
            for (int b1 = 0; b1 < 4; b1++) begin
                wr(4, pat(b0, b1 + 10), NL'(b0), pat(b1, b0 + 20), NL'(b1), "R4");
                rd(4, "R7");
            end
        // R7: read then write same address returns old data
        rd(6, "R7");
        wr(6, pat(6, 50), '0, pat(7, 50), '0, "R3");
        rd(6, "R7");
        // R5: write wrapping at the top address
        wr(DEPTH - 1, pat(1, 60), '0, pat(2, 60), '0, "R5");
        rd(DEPTH - 1, "R5");
        rd(0, "R5");
        nop("R1");
        // R8: output phase taken from c (driven opposite to k)
        rd(2, "R8");
        cswap = 1'b1;
        rd(9, "R8");
        nop("R8");
        cswap = 1'b0;
        nop("R1");
        // R10: reset cancels a pending read burst
        rd(5, "R10");
        cyc(1, 1, 1, 0, '0, '1, '0, '1, "R10");
        cyc(0, 1, 1, 0, '0, '1, '0, '1, "R10");
        nop("R1");
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule